// File: doc/BRIEF.md
# Copyback Buffer with Line Gathering

This block stages dirty cache lines on their way from the cache to memory. Each evicted line (64 bytes, named by its line address, that is the byte address divided by 64) is written into a 16-entry circular store. The store drains in arrival order. When the oldest line is drained, it is merged with the lines that follow it directly, as long as their line addresses keep counting up by one. At most four lines are merged, and a merged block never crosses a 256-byte aligned group. Each block goes to memory as a single write burst: a request phase carries the start line address and the line count, then one data beat per line follows.

A lookup port compares a line address against every held entry in the same cycle. If the line is present, the port returns the data of the youngest copy, so a read miss never fetches stale memory. Entries stay valid until the final beat of their burst is accepted. Uncached single-word stores are staged elsewhere and do not pass through this block.

The control path is one state machine with three states. `ST_IDLE` moves to `ST_REQ` on *launch* (at least one line is held). `ST_REQ` moves to `ST_DATA` on *grant* (`req_ready` high). `ST_DATA` stays in `ST_DATA` on *beat* (a beat is accepted that is not the last one). `ST_DATA` returns to `ST_IDLE` on *retire* (the last beat is accepted, which frees the block's entries).

Top module: `cbuf_top`

## Requirements
- R1: After reset, `in_ready` is 1, `req_valid` and `wvalid` are 0, and `lk_hit` is 0 for any address.
- R2: A line is stored on each clock edge where `in_valid` and `in_ready` are both high. `in_ready` is 0 exactly while 16 lines are held. A line offered while `in_ready` is 0 is not stored and cannot be found by lookup.
- R3: Blocks leave in arrival order. `req_addr` is always the line address of the oldest held line. No request or beat appears while the buffer is empty.
- R4: A block contains the oldest line plus each directly following held line whose address is the previous line address plus 1, up to 4 lines in total. `req_lines` carries the count as a plain binary number from 1 to 4.
- R5: A block never crosses a 4-line (256-byte) aligned group: `req_addr[1:0] + req_lines <= 4`.
- R6: `req_addr` and `req_lines` hold steady while `req_valid` is high and `req_ready` is low. After the grant, exactly `req_lines` beats follow, oldest line first. `wlast` is high only on the final beat. `wdata` holds steady while `wready` is low.
- R7: The lines of a block are released only on the edge that accepts the final beat. Until that edge they still count toward `in_ready` and are still returned by lookup.
- R8: `lk_hit` and `lk_data` follow `lk_addr` combinationally. When several held entries match, the data of the youngest one is returned.
- R9: The block length is fixed on the edge that raises the request. A line stored on that edge or later is not merged into that block.
- R10: A line accepted on edge e while the buffer is idle and empty makes `req_valid` go high after edge e+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Evicted line offered |
| in_ready | output | 1 | Space available for a line |
| in_addr | input | LA_W | Line address of the offered line |
| in_data | input | LINE_W | Line contents |
| req_valid | output | 1 | Burst request pending |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | LA_W | First line address of the burst |
| req_lines | output | LEN_W | Lines in the burst, 1 to 4 |
| wvalid | output | 1 | Data beat valid |
| wready | input | 1 | Memory accepts the beat |
| wdata | output | LINE_W | One line of burst data |
| wlast | output | 1 | Final beat of the burst |
| lk_addr | input | LA_W | Line address to look up |
| lk_hit | output | 1 | Line currently held |
| lk_data | output | LINE_W | Data of the youngest matching entry |

## Verification
Each result has a fixed due cycle. A line accepted on edge e can be seen by lookup right after that edge. Its request appears after edge e+1 if the machine was idle. The first beat appears after the edge that grants the request, and the entries disappear after the edge that takes the final beat. The driver and the sink both act on falling edges. The driver records every accepted line together with the number of the rising edge that stores it. When the monitor sees a request go high, it computes the expected burst length only from lines stored before the raising edge, which enforces R9 without guessing at timing. Directed steps sample `req_valid`, `in_ready` and the lookup outputs in exactly the cycles given above.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

    // Drain-side control states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2
    } cb_state_e;

endpackage

// File: rtl/cbuf_store.sv
// Circular line store: write at tail, release a run of lines at head.
module cbuf_store #(
    parameter int DEPTH  = 16,
    parameter int LA_W   = 26,
    parameter int LINE_W = 512,
    parameter int LEN_W  = 3,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LA_W-1:0]   push_addr,
    input  logic [LINE_W-1:0] push_data,
    input  logic              pop,
    input  logic [LEN_W-1:0]  pop_lines,
    output logic [PTR_W-1:0]  head,
    output logic [CNT_W-1:0]  count,
    output logic [LA_W-1:0]   ent_addr [DEPTH],
    output logic [LINE_W-1:0] ent_data [DEPTH]
);

    logic [PTR_W-1:0]  tail_q;
    logic [PTR_W-1:0]  head_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  count_d;
    logic [LA_W-1:0]   addr_mem [DEPTH];
    logic [LINE_W-1:0] data_mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push && tail_q == PTR_W'(e)) begin
                addr_mem[e] <= push_addr;
                data_mem[e] <= push_data;
            end
        end
        assign ent_addr[e] = addr_mem[e];
        assign ent_data[e] = data_mem[e];
    end

    always_comb begin
        count_d = count_q + CNT_W'(push);
        if (pop) begin
            count_d = count_d - CNT_W'(pop_lines);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) begin
                tail_q <= tail_q + PTR_W'(1);
            end
            if (pop) begin
                head_q <= head_q + PTR_W'(pop_lines);
            end
            count_q <= count_d;
        end
    end

    assign head  = head_q;
    assign count = count_q;

endmodule

// File: rtl/cbuf_gather.sv
// Length of the address-consecutive run starting at the head entry.
module cbuf_gather #(
    parameter int DEPTH  = 16,
    parameter int LA_W   = 26,
    parameter int GMAX   = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1,
    localparam int GRP_W = $clog2(GMAX),
    localparam int LEN_W = GRP_W + 1
) (
    input  logic [PTR_W-1:0] head,
    input  logic [CNT_W-1:0] count,
    input  logic [LA_W-1:0]  ent_addr [DEPTH],
    output logic [LEN_W-1:0] run_len
);

    logic [PTR_W-1:0] idx;
    logic [LA_W-1:0]  base;
    logic [GRP_W:0]   base_off;
    logic             chain;

    assign base     = ent_addr[head];
    assign base_off = {1'b0, base[GRP_W-1:0]};

    always_comb begin
        run_len = LEN_W'(1);
        chain   = 1'b1;
        idx     = head;
        for (int k = 1; k < GMAX; k++) begin
            idx = head + PTR_W'(k);
            if (chain
                && (CNT_W'(k) < count)
                && (ent_addr[idx] == base + LA_W'(k))
                && ((base_off + (GRP_W+1)'(k)) < (GRP_W+1)'(GMAX))) begin
                run_len = LEN_W'(k + 1);
            end else begin
                chain = 1'b0;
            end
        end
    end

endmodule

// File: rtl/cbuf_lookup.sv
// Associative search over held entries; the youngest match wins.
module cbuf_lookup #(
    parameter int DEPTH  = 16,
    parameter int LA_W   = 26,
    parameter int LINE_W = 512,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic [PTR_W-1:0]  head,
    input  logic [CNT_W-1:0]  count,
    input  logic [LA_W-1:0]   ent_addr [DEPTH],
    input  logic [LINE_W-1:0] ent_data [DEPTH],
    input  logic [LA_W-1:0]   q_addr,
    output logic              q_hit,
    output logic [LINE_W-1:0] q_data
);

    logic [PTR_W-1:0] idx;
    logic [PTR_W-1:0] sel;

    always_comb begin
        q_hit = 1'b0;
        sel   = head;
        idx   = head;
        for (int i = 0; i < DEPTH; i++) begin
            idx = head + PTR_W'(i);
            if ((CNT_W'(i) < count) && (ent_addr[idx] == q_addr)) begin
                q_hit = 1'b1;
                sel   = idx;
            end
        end
    end

    assign q_data = ent_data[sel];

endmodule

// File: rtl/cbuf_top.sv
// Copyback staging buffer with gathering of consecutive lines into bursts.
module cbuf_top
    import cbuf_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int LINE_BYTES = 64,
    parameter int LA_W       = 26,
    parameter int GMAX       = 4,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int PTR_W     = $clog2(DEPTH),
    localparam int CNT_W     = PTR_W + 1,
    localparam int LEN_W     = $clog2(GMAX) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LA_W-1:0]   in_addr,
    input  logic [LINE_W-1:0] in_data,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [LA_W-1:0]   req_addr,
    output logic [LEN_W-1:0]  req_lines,
    output logic              wvalid,
    input  logic              wready,
    output logic [LINE_W-1:0] wdata,
    output logic              wlast,
    input  logic [LA_W-1:0]   lk_addr,
    output logic              lk_hit,
    output logic [LINE_W-1:0] lk_data
);

    cb_state_e         state_q, state_d;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  beat_q;
    logic [LEN_W-1:0]  run_len;
    logic [PTR_W-1:0]  head;
    logic [CNT_W-1:0]  count;
    logic [LA_W-1:0]   ent_addr [DEPTH];
    logic [LINE_W-1:0] ent_data [DEPTH];
    logic              push;
    logic              pop;
    logic              launch;
    logic              last_beat;

    assign in_ready  = (count != CNT_W'(DEPTH));
    assign push      = in_valid && in_ready;
    assign launch    = (state_q == ST_IDLE) && (count != '0);
    assign last_beat = (beat_q == LEN_W'(len_q - LEN_W'(1)));

    cbuf_store #(
        .DEPTH (DEPTH),
        .LA_W  (LA_W),
        .LINE_W(LINE_W),
        .LEN_W (LEN_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_addr(in_addr),
        .push_data(in_data),
        .pop      (pop),
        .pop_lines(len_q),
        .head     (head),
        .count    (count),
        .ent_addr (ent_addr),
        .ent_data (ent_data)
    );

    cbuf_gather #(
        .DEPTH(DEPTH),
        .LA_W (LA_W),
        .GMAX (GMAX)
    ) u_gather (
        .head    (head),
        .count   (count),
        .ent_addr(ent_addr),
        .run_len (run_len)
    );

    cbuf_lookup #(
        .DEPTH (DEPTH),
        .LA_W  (LA_W),
        .LINE_W(LINE_W)
    ) u_lookup (
        .head    (head),
        .count   (count),
        .ent_addr(ent_addr),
        .ent_data(ent_data),
        .q_addr  (lk_addr),
        .q_hit   (lk_hit),
        .q_data  (lk_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Block length frozen at launch, beat index within the burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= LEN_W'(1);
            beat_q <= '0;
        end else begin
            if (launch) begin
                len_q <= run_len;
            end
            if (state_q == ST_REQ) begin
                beat_q <= '0;
            end else if (state_q == ST_DATA && wready && !last_beat) begin
                beat_q <= beat_q + LEN_W'(1);
            end
        end
    end

    // Next state: launch, grant, beat, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (count != '0)            state_d = ST_REQ;
            ST_REQ:  if (req_ready)              state_d = ST_DATA;
            ST_DATA: if (wready && last_beat)    state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_valid = 1'b0;
        wvalid    = 1'b0;
        pop       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ:  req_valid = 1'b1;
            ST_DATA: begin
                wvalid = 1'b1;
                pop    = wready && last_beat;
            end
            default: ;
        endcase
    end

    assign req_addr  = ent_addr[head];
    assign req_lines = len_q;
    assign wdata     = ent_data[head + PTR_W'(beat_q)];
    assign wlast     = last_beat;

endmodule

// File: rtl/cbuf_top_chk.sv
// Port-level protocol checker, bound to cbuf_top.
module cbuf_top_chk #(
    parameter int DEPTH  = 16,
    parameter int LA_W   = 26,
    parameter int GMAX   = 4,
    parameter int LINE_W = 512,
    parameter int LEN_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LA_W-1:0]   req_addr,
    input logic [LEN_W-1:0]  req_lines,
    input logic              wvalid,
    input logic              wready,
    input logic [LINE_W-1:0] wdata,
    input logic              wlast
);

    localparam int OCC_W = $clog2(DEPTH) + 2;
    localparam int GRP_W = $clog2(GMAX);

    logic [OCC_W-1:0] occ;
    logic [LEN_W-1:0] lines_c;
    logic [LEN_W-1:0] beat_c;
    logic [GRP_W+LEN_W:0] span;

    assign span = (GRP_W+LEN_W+1)'(req_addr[GRP_W-1:0]) + (GRP_W+LEN_W+1)'(req_lines);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ     <= '0;
            lines_c <= '0;
            beat_c  <= '0;
        end else begin
            occ <= occ + OCC_W'(in_valid && in_ready)
                       - ((wvalid && wready && wlast) ? OCC_W'(lines_c) : OCC_W'(0));
            if (req_valid && req_ready) begin
                lines_c <= req_lines;
                beat_c  <= '0;
            end else if (wvalid && wready) begin
                beat_c <= beat_c + LEN_W'(1);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH));                                               // R2
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_W'(DEPTH)) |-> !in_ready);                               // R2
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> (!req_valid && !wvalid));                            // R3
    AST_LINES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_lines >= LEN_W'(1) && req_lines <= LEN_W'(GMAX))); // R4
    AST_NO_GROUP_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (span <= (GRP_W+LEN_W+1)'(GMAX)));                     // R5
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_lines))); // R6
    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wlast))); // R6
    AST_LAST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid |-> (wlast == (beat_c == LEN_W'(lines_c - LEN_W'(1)))));      // R6
    AST_NO_DOUBLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && wvalid));                                             // R6

endmodule

bind cbuf_top cbuf_top_chk #(
    .DEPTH (DEPTH),
    .LA_W  (LA_W),
    .GMAX  (GMAX),
    .LINE_W(LINE_W),
    .LEN_W (LEN_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .req_lines(req_lines),
    .wvalid   (wvalid),
    .wready   (wready),
    .wdata    (wdata),
    .wlast    (wlast)
);

// File: tb/test_cbuf_top.sv
module test_cbuf_top;

    localparam int LA_W   = 26;
    localparam int LINE_W = 512;
    localparam int LEN_W  = 3;

    typedef struct {
        logic [LA_W-1:0]   a;
        logic [LINE_W-1:0] d;
        int                acc;
    } line_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [LA_W-1:0]   in_addr = '0;
    logic [LINE_W-1:0] in_data = '0;
    logic              req_valid;
    logic              req_ready = 1'b0;
    logic [LA_W-1:0]   req_addr;
    logic [LEN_W-1:0]  req_lines;
    logic              wvalid;
    logic              wready = 1'b0;
    logic [LINE_W-1:0] wdata;
    logic              wlast;
    logic [LA_W-1:0]   lk_addr = '0;
    logic              lk_hit;
    logic [LINE_W-1:0] lk_data;

    int    nchk = 0, nfail = 0;
    int    cyc = 0;
    int    seq = 0;
    int    pend = 0;
    line_t model[$];

    bit    sink_en = 0, throttle = 0, wstall = 0;
    int    mphase = 0, beat = 0, exp_len = 0;
    bit    prev_rv = 0;
    int    last_lines = 0, blocks4 = 0, blocks = 0;
    logic [15:0] lfsr = 16'hACE1;

    cbuf_top i_cbuf_top (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_lines(req_lines),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wlast(wlast),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [LINE_W-1:0] mk_data(input logic [LA_W-1:0] a, input int s);
        return {16{s[15:0], a[15:0]}};
    endfunction

    // Driver: offers one line, records it in the scoreboard with its storing edge
    task automatic push_line(input logic [LA_W-1:0] a);
        logic [LINE_W-1:0] d;
        pend++;
        seq++;
        d = mk_data(a, seq);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        model.push_back('{a: a, d: d, acc: cyc + 1});
        pend--;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic wait_empty();
        while (model.size() != 0 || pend != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic look(input logic [LA_W-1:0] a);
        @(negedge clk);
        lk_addr = a;
        #1;
    endtask

    // Monitor / sink: checks every burst against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (rst_n) begin
                if (mphase == 0) begin
                    wready = 1'b0;
                    if (req_valid && !prev_rv) begin
                        int avail;
                        avail = 0;
                        foreach (model[i]) if (model[i].acc < cyc && avail == i) avail++;
                        exp_len = 1;
                        while (exp_len < 4 && exp_len < avail
                               && model[exp_len].a == model[0].a + exp_len
                               && (int'(model[0].a[1:0]) + exp_len) < 4)
                            exp_len++;
                        chk(avail > 0, "R3 request with no stored line", avail, 1);
                        if (avail > 0) begin
                            chk(req_addr == model[0].a, "R3 start address", req_addr, model[0].a);
                            chk(int'(req_lines) == exp_len, "R4/R9 line count", req_lines, exp_len);
                            chk(int'(req_addr[1:0]) + int'(req_lines) <= 4, "R5 group crossing",
                                req_addr[1:0] + req_lines, 4);
                        end
                        last_lines = int'(req_lines);
                        blocks++;
                        if (req_lines == 3'd4) blocks4++;
                    end
                    req_ready = sink_en && (!throttle || lfsr[0]);
                    if (req_valid && req_ready) begin
                        mphase = 1;
                        beat   = 0;
                    end
                end else begin
                    req_ready = 1'b0;
                    wready = sink_en && !wstall && (!throttle || lfsr[1]);
                    if (wvalid && wready) begin
                        chk(wdata == model[beat].d, "R6 beat data", wdata[63:0], model[beat].d[63:0]);
                        chk(wlast == (beat == exp_len - 1), "R6 last flag", wlast, beat == exp_len - 1);
                        beat++;
                        if (beat == exp_len) begin
                            repeat (exp_len) void'(model.pop_front());
                            mphase = 0;
                        end
                    end
                end
            end
            prev_rv = req_valid;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [LA_W-1:0] ra;
        repeat (3) @(negedge clk);
        lk_addr = 26'd5;
        #1;
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        chk(req_valid == 1'b0, "R1 req_valid after reset", req_valid, 0);
        chk(wvalid == 1'b0, "R1 wvalid after reset", wvalid, 0);
        chk(lk_hit == 1'b0, "R1 lookup after reset", lk_hit, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(in_ready == 1'b1 && req_valid == 1'b0, "R1 idle after reset release", {in_ready, req_valid}, 2'b10);

        // R10: request latency from an idle empty buffer
        sink_en = 1;
        push_line(26'h40);
        @(negedge clk);
        chk(req_valid == 1'b0, "R10 request not yet raised after storing edge", req_valid, 0);
        @(negedge clk);
        chk(req_valid == 1'b1, "R10 request raised one edge later", req_valid, 1);
        wait_empty();

        // R9: a line stored on the raising edge stays out of the block
        push_line(26'h80);
        push_line(26'h81);
        @(negedge clk);
        #1;
        chk(last_lines == 1, "R9 length frozen at launch", last_lines, 1);
        wait_empty();

        // R4/R5: gathering patterns with a stalled sink, then drained
        sink_en = 0;
        push_line(26'd3);
        for (int k = 8; k <= 13; k++) push_line(26'(k));
        push_line(26'd21); push_line(26'd22);
        push_line(26'd30); push_line(26'd31); push_line(26'd32);
        push_line(26'd40); push_line(26'd42);
        push_line(26'd50); push_line(26'd49);
        throttle = 1;
        sink_en  = 1;
        wait_empty();
        chk(blocks4 >= 1, "R4 four-line block seen", blocks4, 1);

        // R2/R7: full buffer back-pressure and late release
        throttle = 0;
        sink_en  = 0;
        blocks   = 0;
        for (int k = 0; k < 16; k++) push_line(26'(300 + k));
        @(negedge clk);
        chk(in_ready == 1'b0, "R2 not ready with 16 held", in_ready, 0);
        fork
            push_line(26'd999);
        join_none
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R2 still not ready while full", in_ready, 0);
        look(26'd999);
        chk(lk_hit == 1'b0, "R2 refused line not held", lk_hit, 0);
        look(26'd300);
        chk(lk_hit == 1'b1, "R7 head held before drain", lk_hit, 1);
        wstall  = 1;
        sink_en = 1;
        repeat (5) @(negedge clk);
        #1;
        chk(wvalid == 1'b1, "R6 beat waiting on stalled sink", wvalid, 1);
        chk(in_ready == 1'b0, "R7 entries kept while burst open", in_ready, 0);
        look(26'd300);
        chk(lk_hit == 1'b1, "R7 lookup hit while burst open", lk_hit, 1);
        wstall = 0;
        wait_empty();
        look(26'd300);
        chk(lk_hit == 1'b0, "R7 released after final beat", lk_hit, 0);
        look(26'd999);
        chk(lk_hit == 1'b0, "R7 late line drained", lk_hit, 0);

        // R8: lookup returns the youngest copy
        sink_en = 0;
        push_line(26'd200);
        push_line(26'd201);
        push_line(26'd200);
        look(26'd200);
        chk(lk_hit == 1'b1, "R8 hit on duplicated line", lk_hit, 1);
        chk(lk_data == model[2].d, "R8 youngest data", lk_data[63:0], model[2].d[63:0]);
        look(26'd201);
        chk(lk_hit == 1'b1 && lk_data == model[1].d, "R8 data of single copy", lk_data[63:0], model[1].d[63:0]);
        look(26'd202);
        chk(lk_hit == 1'b0, "R8 miss on absent line", lk_hit, 0);
        sink_en = 1;
        wait_empty();

        // Mixed traffic with a throttled sink
        throttle = 1;
        ra = 26'd1000;
        for (int k = 0; k < 60; k++) begin
            push_line(ra);
            ra = ra + (($urandom_range(0, 7) == 0) ? 26'd5 : 26'd1);
        end
        wait_empty();
        chk(req_valid == 1'b0 && wvalid == 1'b0, "R3 quiet when empty", {req_valid, wvalid}, 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule